// File: doc/BRIEF.md
# Threshold DMA Data FIFO

This block is the byte buffer that sits between a disk controller's host-facing register port and its controller core. Command parameter bytes and sector data both pass through it. The host side sees a data register, which is reached either by a register address or by a DMA acknowledge, and a DMA request line. The core side pushes and pops single bytes. The direction of flow is set at the start of each execution phase: host-to-core for disk writes and core-to-host for disk reads.

Outside an execution phase, and whenever the configured enable is off, the buffer holds only one byte. In that state every byte is handshaked through the ready and direction status. During execution with the enable on, it uses its full depth. It raises the DMA request once a programmable threshold of free space (on writes) or of stored bytes (on reads) is reached. Two conditions end the transfer and stay latched until the next command starts: the core popping from an empty buffer (underrun, which is padded with zero bytes) and the core pushing into a full one (overrun). A configure strobe loads the enable, the threshold and a lock bit. The lock bit keeps the enable and threshold through a software reset.

Top module: `thresh_xfer_fifo`

## Requirements
- R1: After the asynchronous reset the block is idle in host-to-core direction: dmaReq=0, hostReady=1, hostDirOut=0, overrun=0, underrun=0, coreHasData=0, and the configured enable is off.
- R2: Outside an execution phase, the buffer holds one byte. After one accepted host write, hostReady=0 and further host writes are dropped until the core pops the byte.
- R3: During execution with the enable on, the buffer holds DEPTH (16) bytes and returns them in the order written, on both directions.
- R4: In execution with hostDirOut=0 (execDir=0, host to core), dmaReq rises once free space is at least threshold+1 bytes. It then stays high until the buffer is full. It is never high outside execution.
- R5: In execution with hostDirOut=1 (execDir=1, core to host), dmaReq rises once the stored count is at least threshold+1 bytes. It then stays high until the buffer is empty.
- R6: An execStart pulse flushes the buffer, so stale bytes are never transferred.
- R7: A host read or write reaches the data register when dmaAck=1 whatever hostAddr holds, or when dmaAck=0 and hostAddr equals DATA_ADDR (5). Any other access is ignored.
- R8: During a host-to-core execution phase, a core pop from an empty buffer returns corePopData=0x00 and sets underrun. Underrun stays set until cmdStart or softRst, and while it is set dmaReq=0 and hostReady=0.
- R9: During a core-to-host execution phase, a core push into a full buffer drops the byte and sets overrun. Overrun stays set until cmdStart or softRst, and while it is set dmaReq=0 and hostReady=0.
- R10: softRst flushes the buffer and returns to idle. It keeps the enable and threshold when the lock bit is set, and turns the enable off when the lock bit is clear.
- R11: With the configured enable off, an execution phase runs in single-byte mode, with an effective threshold of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softRst | input | 1 | Software reset pulse |
| cfgLoad | input | 1 | Load the enable, threshold and lock values |
| cfgEnable | input | 1 | Deep buffer enable value |
| cfgThresh | input | THR_W | Service threshold value |
| cfgLock | input | 1 | Keep settings across software reset |
| cmdStart | input | 1 | A new command begins |
| execStart | input | 1 | Execution phase begins |
| execDir | input | 1 | Execution direction, 1 = core to host |
| hostAddr | input | ADDR_W | Host register address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Head byte offered to host reads |
| dmaAck | input | 1 | DMA acknowledge, selects the data register |
| dmaReq | output | 1 | DMA service request |
| hostReady | output | 1 | Data register ready for the host |
| hostDirOut | output | 1 | 1 = host must read, 0 = host must write |
| corePush | input | 1 | Core pushes a byte (core to host flow) |
| corePushData | input | DATA_W | Byte pushed by the core |
| corePop | input | 1 | Core pops a byte (host to core flow) |
| corePopData | output | DATA_W | Byte offered to the core, zero when empty or stopped |
| coreHasData | output | 1 | A byte is waiting for the core |
| coreHasRoom | output | 1 | Space is free for a core push |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The properties assume that cmdStart, execStart and softRst are one-cycle pulses and are never raised together. They also assume that the core and the host use only the side of the buffer that matches the current direction. The stimulus meets these assumptions by driving every control pulse from its own task and by clearing it one cycle later. A threshold sweep covers every value of the four-bit field in both directions at full depth. Separate sequences cause each error on purpose, after which the bench checks that the latched state holds until the next command.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2
  } phase_e;

  // strobes from control to storage
  typedef struct packed {
    logic flush;
    logic push;
    logic pushFromCore;
    logic pop;
    logic zeroOut;
  } storeCtl_t;

endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  storeCtl_t                      ctl,
  input  logic [DATA_W-1:0]              hostData,
  input  logic [DATA_W-1:0]              coreData,
  output logic [$clog2(DEPTH+1)-1:0]     fillCount,
  output logic [DATA_W-1:0]              headData,
  output logic [DATA_W-1:0]              corePopData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push && !ctl.flush) begin
      mem[wrPtr] <= ctl.pushFromCore ? coreData : hostData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end

  assign fillCount   = count;
  assign headData    = mem[rdPtr];
  assign corePopData = ctl.zeroOut ? '0 : mem[rdPtr];

endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        softRst,
  input  logic                        cfgLoad,
  input  logic                        cfgEnable,
  input  logic [THR_W-1:0]            cfgThresh,
  input  logic                        cfgLock,
  input  logic                        cmdStart,
  input  logic                        execStart,
  input  logic                        execDir,
  input  logic                        hostWrSel,
  input  logic                        hostRdSel,
  input  logic                        corePush,
  input  logic                        corePop,
  input  logic [$clog2(DEPTH+1)-1:0]  fillCount,
  output storeCtl_t                   ctl,
  output logic                        dmaReq,
  output logic                        hostReady,
  output logic                        hostDirOut,
  output logic                        coreHasData,
  output logic                        coreHasRoom,
  output logic                        overrun,
  output logic                        underrun,
  output logic                        inExec
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  phase_e           phase;
  logic             dirRead;
  logic             enReg, lockReg;
  logic [THR_W-1:0] thrReg;

  logic             effEn, errFlag, ctlBlock, isFull, isEmpty;
  logic [CNT_W-1:0] capCnt, cntNext;
  logic [CMP_W-1:0] thrPlusOne, freeNext, usedNext;
  logic             hostPush, hostPop, corePushOk, corePopOk;
  logic             overrunHit, underrunHit, errNext, reqNext;

  assign inExec   = (phase == PH_EXEC);
  assign effEn    = inExec && enReg;
  assign capCnt   = effEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thrPlusOne = effEn ? (CMP_W'(thrReg) + CMP_W'(1)) : CMP_W'(1);
  assign errFlag  = overrun || underrun;
  assign ctlBlock = softRst || cmdStart || execStart;
  assign isFull   = (fillCount >= capCnt);
  assign isEmpty  = (fillCount == '0);

  // host to core flow
  assign hostPush    = !dirRead && hostWrSel && !isFull  && !errFlag && !ctlBlock;
  assign corePopOk   = !dirRead && corePop   && !isEmpty && !errFlag && !ctlBlock;
  assign underrunHit = !dirRead && corePop   && isEmpty  && inExec && !errFlag && !ctlBlock;
  // core to host flow
  assign corePushOk  = dirRead && corePush  && !isFull  && !errFlag && !ctlBlock;
  assign hostPop     = dirRead && hostRdSel && !isEmpty && !errFlag && !ctlBlock;
  assign overrunHit  = dirRead && corePush  && isFull   && inExec && !errFlag && !ctlBlock;

  always_comb begin
    ctl.flush        = ctlBlock;
    ctl.push         = dirRead ? corePushOk : hostPush;
    ctl.pushFromCore = dirRead;
    ctl.pop          = dirRead ? hostPop : corePopOk;
    ctl.zeroOut      = errFlag || isEmpty;
  end

  assign cntNext  = fillCount + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
  assign usedNext = CMP_W'(cntNext);
  assign freeNext = CMP_W'(capCnt) - CMP_W'(cntNext);
  assign errNext  = errFlag || overrunHit || underrunHit;

  always_comb begin
    reqNext = dmaReq;
    if (ctlBlock || !inExec || errNext) begin
      reqNext = 1'b0;
    end else if (!dirRead) begin
      if (freeNext == '0)              reqNext = 1'b0;
      else if (freeNext >= thrPlusOne) reqNext = 1'b1;
    end else begin
      if (usedNext == '0)              reqNext = 1'b0;
      else if (usedNext >= thrPlusOne) reqNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      thrReg   <= '0;
      lockReg  <= 1'b0;
      phase    <= PH_IDLE;
      dirRead  <= 1'b0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      if (cfgLoad) begin
        enReg   <= cfgEnable;
        thrReg  <= cfgThresh;
        lockReg <= cfgLock;
      end else if (softRst && !lockReg) begin
        enReg  <= 1'b0;
        thrReg <= '0;
      end

      if (softRst) begin
        phase   <= PH_IDLE;
        dirRead <= 1'b0;
      end else if (cmdStart) begin
        phase   <= PH_CMD;
        dirRead <= 1'b0;
      end else if (execStart) begin
        phase   <= PH_EXEC;
        dirRead <= execDir;
      end

      if (softRst || cmdStart) begin
        overrun  <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (overrunHit)  overrun  <= 1'b1;
        if (underrunHit) underrun <= 1'b1;
      end

      dmaReq <= reqNext;
    end
  end

  assign hostReady   = !errFlag && (dirRead ? !isEmpty : !isFull);
  assign hostDirOut  = dirRead;
  assign coreHasData = !dirRead && !isEmpty;
  assign coreHasRoom = dirRead && !isFull;

endmodule

// File: rtl/thresh_xfer_fifo.sv
module thresh_xfer_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 8,
  parameter int THR_W     = 4,
  parameter int ADDR_W    = 3,
  parameter int DATA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              cfgLoad,
  input  logic              cfgEnable,
  input  logic [THR_W-1:0]  cfgThresh,
  input  logic              cfgLock,
  input  logic              cmdStart,
  input  logic              execStart,
  input  logic              execDir,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              dmaAck,
  output logic              dmaReq,
  output logic              hostReady,
  output logic              hostDirOut,
  input  logic              corePush,
  input  logic [DATA_W-1:0] corePushData,
  input  logic              corePop,
  output logic [DATA_W-1:0] corePopData,
  output logic              coreHasData,
  output logic              coreHasRoom,
  output logic              overrun,
  output logic              underrun
);

  localparam int CNT_W = $clog2(DEPTH+1);

  storeCtl_t        ctl;
  logic [CNT_W-1:0] fillCount;
  logic             inExec;
  logic             dataSel;

  // acknowledge alone selects the data register
  assign dataSel = dmaAck || (hostAddr == ADDR_W'(DATA_ADDR));

  xfer_fifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .cfgLoad    (cfgLoad),
    .cfgEnable  (cfgEnable),
    .cfgThresh  (cfgThresh),
    .cfgLock    (cfgLock),
    .cmdStart   (cmdStart),
    .execStart  (execStart),
    .execDir    (execDir),
    .hostWrSel  (hostWr && dataSel),
    .hostRdSel  (hostRd && dataSel),
    .corePush   (corePush),
    .corePop    (corePop),
    .fillCount  (fillCount),
    .ctl        (ctl),
    .dmaReq     (dmaReq),
    .hostReady  (hostReady),
    .hostDirOut (hostDirOut),
    .coreHasData(coreHasData),
    .coreHasRoom(coreHasRoom),
    .overrun    (overrun),
    .underrun   (underrun),
    .inExec     (inExec)
  );

  xfer_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hostData   (hostWdata),
    .coreData   (corePushData),
    .fillCount  (fillCount),
    .headData   (hostRdata),
    .corePopData(corePopData)
  );

endmodule

// File: rtl/thresh_xfer_fifo_chk.sv
module thresh_xfer_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cmdStart,
  input logic                        softRst,
  input logic                        execStart,
  input logic                        corePop,
  input logic [DATA_W-1:0]           corePopData,
  input logic [$clog2(DEPTH+1)-1:0]  fillCount,
  input logic                        inExec,
  input logic                        overrun,
  input logic                        underrun,
  input logic                        dmaReq,
  input logic                        hostReady
);

  p_byte_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inExec |-> fillCount <= 1);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= ($clog2(DEPTH+1))'(DEPTH));

  p_req_needs_exec_r4: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> inExec);

  p_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    execStart |=> fillCount == '0);

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (corePop && fillCount == '0) |-> corePopData == '0);

  p_sticky_under_r8: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !cmdStart && !softRst) |=> underrun);

  p_sticky_over_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !cmdStart && !softRst) |=> overrun);

  p_stop_on_error_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun || underrun) |-> (!dmaReq && !hostReady));

endmodule

bind thresh_xfer_fifo thresh_xfer_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdStart   (cmdStart),
  .softRst    (softRst),
  .execStart  (execStart),
  .corePop    (corePop),
  .corePopData(corePopData),
  .fillCount  (fillCount),
  .inExec     (inExec),
  .overrun    (overrun),
  .underrun   (underrun),
  .dmaReq     (dmaReq),
  .hostReady  (hostReady)
);

// File: tb/sim_thresh_xfer_fifo.sv
`timescale 1ns/1ps
module sim_thresh_xfer_fifo;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 0, cfgLoad = 0, cfgEnable = 0, cfgLock = 0;
  logic [3:0] cfgThresh = '0;
  logic       cmdStart = 0, execStart = 0, execDir = 0;
  logic [2:0] hostAddr = '0;
  logic       hostWr = 0, hostRd = 0, dmaAck = 0;
  logic [7:0] hostWdata = '0, corePushData = '0;
  logic       corePush = 0, corePop = 0;
  logic [7:0] hostRdata, corePopData;
  logic       dmaReq, hostReady, hostDirOut, coreHasData, coreHasRoom;
  logic       overrun, underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  thresh_xfer_fifo u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cfgLoad(cfgLoad),
    .cfgEnable(cfgEnable), .cfgThresh(cfgThresh), .cfgLock(cfgLock),
    .cmdStart(cmdStart), .execStart(execStart), .execDir(execDir),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .dmaAck(dmaAck),
    .dmaReq(dmaReq), .hostReady(hostReady), .hostDirOut(hostDirOut),
    .corePush(corePush), .corePushData(corePushData), .corePop(corePop),
    .corePopData(corePopData), .coreHasData(coreHasData),
    .coreHasRoom(coreHasRoom), .overrun(overrun), .underrun(underrun)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input bit en, input int thr, input bit lock);
    cfgLoad = 1; cfgEnable = en; cfgThresh = 4'(thr); cfgLock = lock;
    tick();
    cfgLoad = 0;
  endtask

  task automatic newCommand();
    cmdStart = 1; tick(); cmdStart = 0;
  endtask

  task automatic startExec(input bit dir);
    execStart = 1; execDir = dir; tick(); execStart = 0;
    tick();
  endtask

  task automatic dmaWrite(input int d);
    dmaAck = 1; hostWr = 1; hostWdata = 8'(d); hostAddr = 3'd0;
    tick();
    dmaAck = 0; hostWr = 0;
  endtask

  task automatic regWrite(input int a, input int d);
    hostAddr = 3'(a); hostWr = 1; hostWdata = 8'(d);
    tick();
    hostWr = 0;
  endtask

  task automatic dmaRead(input string req, input int exp);
    dmaAck = 1; hostRd = 1;
    check(req, int'(hostRdata), exp);
    tick();
    dmaAck = 0; hostRd = 0;
  endtask

  task automatic pop(input string req, input int exp);
    corePop = 1;
    check(req, int'(corePopData), exp);
    tick();
    corePop = 0;
  endtask

  task automatic push(input int d);
    corePush = 1; corePushData = 8'(d);
    tick();
    corePush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();

    // R1: reset state
    check("R1 dmaReq", dmaReq, 0);
    check("R1 hostReady", hostReady, 1);
    check("R1 hostDirOut", hostDirOut, 0);
    check("R1 overrun", overrun, 0);
    check("R1 underrun", underrun, 0);
    check("R1 coreHasData", coreHasData, 0);

    // R2: single byte register during command phase, even with enable set
    configure(1, 8, 0);
    newCommand();
    regWrite(5, 8'hA5);
    check("R2 hasData", coreHasData, 1);
    check("R2 notReady", hostReady, 0);
    regWrite(5, 8'h3C);
    pop("R2 first byte", 8'hA5);
    check("R2 second write dropped", coreHasData, 0);
    check("R2 ready again", hostReady, 1);

    // R7: address decode versus acknowledge
    regWrite(2, 8'h11);
    check("R7 wrong address ignored", coreHasData, 0);
    dmaAck = 1; regWrite(2, 8'h22); dmaAck = 0;
    check("R7 ack ignores address", coreHasData, 1);
    pop("R7 ack data", 8'h22);

    // R3 R4: host to core threshold sweep
    for (int t = 0; t < 16; t++) begin
      configure(1, t, 0);
      newCommand();
      startExec(0);
      check("R4 req at empty", dmaReq, 1);
      for (int i = 0; i < DEPTH; i++) begin
        dmaWrite((t * 17 + i) & 255);
        check("R4 req while filling", dmaReq, (i < DEPTH - 1) ? 1 : 0);
      end
      check("R3 full not ready", hostReady, 0);
      for (int k = 0; k < DEPTH; k++) begin
        pop("R3 write order", (t * 17 + k) & 255);
        check("R4 req while draining", dmaReq, (k >= t) ? 1 : 0);
      end
    end

    // R3 R5: core to host threshold sweep
    for (int t = 0; t < 16; t++) begin
      configure(1, t, 0);
      newCommand();
      startExec(1);
      check("R5 direction", hostDirOut, 1);
      check("R5 req empty", dmaReq, 0);
      for (int i = 0; i < DEPTH; i++) begin
        push((t * 29 + i) & 255);
        check("R5 req while filling", dmaReq, (i >= t) ? 1 : 0);
      end
      check("R3 no room", coreHasRoom, 0);
      for (int k = 0; k < DEPTH; k++) begin
        dmaRead("R3 read order", (t * 29 + k) & 255);
        check("R5 req while draining", dmaReq, (k < DEPTH - 1) ? 1 : 0);
      end
    end

    // R9: overrun
    configure(1, 3, 0);
    newCommand();
    startExec(1);
    for (int i = 0; i < DEPTH; i++) push(i);
    push(8'hEE);
    check("R9 overrun set", overrun, 1);
    check("R9 req dropped", dmaReq, 0);
    check("R9 not ready", hostReady, 0);
    tick(); tick();
    check("R9 sticky", overrun, 1);
    newCommand();
    check("R9 cleared by command", overrun, 0);

    // R8: underrun with zero padding
    startExec(0);
    dmaWrite(8'h5A);
    dmaWrite(8'h6B);
    pop("R8 byte0", 8'h5A);
    pop("R8 byte1", 8'h6B);
    check("R8 no underrun yet", underrun, 0);
    pop("R8 pad zero", 0);
    check("R8 underrun set", underrun, 1);
    check("R8 req dropped", dmaReq, 0);
    check("R8 not ready", hostReady, 0);
    dmaWrite(8'h77);
    pop("R8 pad after stop", 0);
    check("R8 sticky", underrun, 1);
    newCommand();
    check("R8 cleared by command", underrun, 0);

    // R6: flush on execution entry
    startExec(0);
    dmaWrite(1); dmaWrite(2); dmaWrite(3);
    check("R6 data present", coreHasData, 1);
    startExec(0);
    check("R6 flushed", coreHasData, 0);

    // R10: lock keeps deep mode across soft reset
    configure(1, 15, 1);
    softRst = 1; tick(); softRst = 0;
    newCommand();
    startExec(0);
    check("R10 locked threshold req", dmaReq, 1);
    dmaWrite(8'h01);
    check("R10 locked deep mode", hostReady, 1);

    // R10 R11: unlocked soft reset drops to byte mode
    configure(1, 15, 0);
    softRst = 1; tick(); softRst = 0;
    newCommand();
    startExec(0);
    check("R11 byte mode req", dmaReq, 1);
    dmaWrite(8'h02);
    check("R10 unlocked byte mode", hostReady, 0);
    check("R11 req off when full", dmaReq, 0);
    pop("R11 byte", 8'h02);
    check("R11 req back", dmaReq, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule